// File: doc/BRIEF.md
# In-Order Completion Queue

This block follows dispatched instructions in program order and lets them retire in that same order. Each dispatched instruction gets a slot in a circular queue. Execution units later report through finish ports that the slot has executed, and they may mark it as faulting. Branches are not finished by the execution units. They become finished when a resolution input reports the branch outcome.

Each cycle the queue shows up to four of its oldest slots as retiring. The lanes form a contiguous run that starts at the oldest entry. The rename buffer uses these lanes to write back and release the matching results. Retirement stops at the first slot that is still busy executing, that faults, or that is an unresolved branch. Because of this, no result can commit past an open speculation. A fault is acted on only when its slot reaches the head of the queue. At that point an exception flag is raised and the slot is held back.

A mispredicted branch removes every younger slot from the queue, and the next dispatch reuses the slot right after the branch. A clear input empties the whole queue.

Top module: `inorder_cq`

## Requirements
- R1: After reset, and in the cycle after `clear_i` is high, the queue is empty. In that state `ret_valid_o` is 0, `exc_o` is 0, `disp_ready_o` is 1 and the next slot number `disp_tag_o` is 0. A dispatch made in the same cycle as `clear_i` is dropped.
- R2: Each accepted dispatch (`disp_valid_i` and `disp_ready_o` both high) takes slot `disp_tag_o`. The next dispatch then gets the following slot number, modulo 16.
- R3: With 16 entries held, `disp_ready_o` is 0. While it stays low, a dispatch attempt leaves `disp_tag_o` unchanged.
- R4: An entry retires only after it has finished and all older entries have retired. An entry that finishes before an older one is held back.
- R5: Up to 4 entries retire per cycle. `ret_valid_o` is a run of ones starting at bit 0. Lane i (`ret_tag_o[4i+3:4i]`) carries the slot i places after the oldest entry.
- R6: A branch entry counts as finished only through `br_valid_i` with `br_tag_i` naming it. Finish-port reports on a branch are ignored. An unresolved branch blocks its own retirement and that of every younger entry.
- R7: A resolution with `br_mispred_i`=1 removes all entries younger than the branch. Those entries never retire, even if they had already finished. In the next cycle `disp_tag_o` equals the branch slot + 1 (mod 16). The branch itself still retires.
- R8: `exc_o` is 1 exactly while the oldest entry has finished with a fault (`fin_exc_i`=1 on its finish report). That entry is never retired. A faulting entry that is not the oldest does not raise `exc_o`.
- R9: In a cycle with a misprediction, `disp_ready_o` is 0 and any dispatch is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Empty the queue and restart slot numbering at 0 |
| disp_valid_i | input | 1 | Dispatch request |
| disp_is_br_i | input | 1 | The dispatched instruction is a speculative branch |
| disp_ready_o | output | 1 | A dispatch is accepted this cycle |
| disp_tag_o | output | 4 | Slot given to the next accepted dispatch |
| fin_valid_i | input | 2 | Per finish port: report valid |
| fin_tag_i | input | 8 | Per finish port: slot finished (port p at bits 4p+3:4p) |
| fin_exc_i | input | 2 | Per finish port: the finished entry faults |
| br_valid_i | input | 1 | Branch resolution valid |
| br_tag_i | input | 4 | Slot of the resolved branch |
| br_mispred_i | input | 1 | The resolved branch was mispredicted |
| ret_valid_o | output | 4 | Retiring lanes this cycle, contiguous from lane 0 |
| ret_tag_o | output | 16 | Slot retiring on each lane (lane i at bits 4i+3:4i) |
| exc_o | output | 1 | The oldest entry has finished with a fault |

## Verification
Finishes are issued in reverse program order. This shows whether the queue waits for the oldest entry and then drains a full group of four in one cycle followed by a partial group. A finished non-branch entry sits behind an unresolved branch, with finished entries younger than the branch. This separates a queue that only checks finish flags from one that also respects speculation and removes wrong-path entries. Filling all 16 slots across the pointer wrap, with two finish ports in use at once, tests the full stall and the modular slot order. A fault reported on a younger entry shows that the exception is tied to the head of the queue and not to the moment of the finish report.

// File: rtl/cq_pkg.sv
package cq_pkg;

  typedef struct packed {
    logic busy;   // slot holds a live instruction
    logic done;   // executed, or resolved when a branch
    logic fault;  // finished with an exception
    logic is_br;  // speculative branch
  } cq_entry_t;

  // slot reached by stepping n places forward from p on a ring of size depth
  function automatic int unsigned ring_fwd(int unsigned p, int unsigned n, int unsigned depth);
    return (p + n) % depth;
  endfunction

  // number of steps from a forward to b on a ring of size depth
  function automatic int unsigned ring_dist(int unsigned a, int unsigned b, int unsigned depth);
    return (b + depth - a) % depth;
  endfunction

  function automatic logic entry_retirable(cq_entry_t e);
    return e.busy & e.done & ~e.fault;
  endfunction

endpackage

// File: rtl/cq_retire_sel.sv
module cq_retire_sel
  import cq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int RETW  = 4,
  localparam int IDXW = $clog2(DEPTH),
  localparam int NW   = $clog2(RETW + 1)
) (
  input  cq_entry_t [DEPTH-1:0] ent_i,
  input  logic [IDXW-1:0]       head_i,
  output logic [RETW-1:0]       lane_go_o,
  output logic [RETW*IDXW-1:0]  lane_slot_o,
  output logic [NW-1:0]         nret_o,
  output logic                  head_fault_o
);

  logic [RETW-1:0] lane_ok;

  for (genvar l = 0; l < RETW; l++) begin : g_lane
    logic [IDXW-1:0] slot;
    assign slot = IDXW'(ring_fwd(32'(head_i), 32'(l), DEPTH));
    assign lane_slot_o[l*IDXW +: IDXW] = slot;
    assign lane_ok[l] = entry_retirable(ent_i[slot]);
  end

  // the run of retiring lanes ends at the first lane that cannot go
  always_comb begin
    logic run;
    run    = 1'b1;
    nret_o = '0;
    for (int l = 0; l < RETW; l++) begin
      run          = run & lane_ok[l];
      lane_go_o[l] = run;
      nret_o       = nret_o + NW'(run);
    end
  end

  assign head_fault_o = ent_i[head_i].busy & ent_i[head_i].done & ent_i[head_i].fault;

endmodule

// File: rtl/cq_ptr_ctl.sv
module cq_ptr_ctl
  import cq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int RETW  = 4,
  localparam int IDXW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int NW   = $clog2(RETW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_i,
  input  logic            push_i,
  input  logic [NW-1:0]   nret_i,
  input  logic            flush_i,
  input  logic [IDXW-1:0] flush_slot_i,
  output logic [IDXW-1:0] head_o,
  output logic [IDXW-1:0] tail_o,
  output logic [CNTW-1:0] count_o
);

  logic [IDXW-1:0] head_nx, tail_nx;
  logic [CNTW-1:0] count_nx;

  always_comb begin
    head_nx = IDXW'(ring_fwd(32'(head_o), 32'(nret_i), DEPTH));
    if (flush_i) begin
      // keep everything up to and including the branch
      tail_nx  = IDXW'(ring_fwd(32'(flush_slot_i), 32'd1, DEPTH));
      count_nx = CNTW'(ring_dist(32'(head_o), 32'(flush_slot_i), DEPTH) + 32'd1 - 32'(nret_i));
    end else begin
      tail_nx  = push_i ? IDXW'(ring_fwd(32'(tail_o), 32'd1, DEPTH)) : tail_o;
      count_nx = count_o + CNTW'(push_i) - CNTW'(nret_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_o  <= '0;
      tail_o  <= '0;
      count_o <= '0;
    end else if (clear_i) begin
      head_o  <= '0;
      tail_o  <= '0;
      count_o <= '0;
    end else begin
      head_o  <= head_nx;
      tail_o  <= tail_nx;
      count_o <= count_nx;
    end
  end

endmodule

// File: rtl/inorder_cq.sv
module inorder_cq
  import cq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int RETW  = 4,
  parameter int NFIN  = 2,
  localparam int IDXW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int NW   = $clog2(RETW + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear_i,
  input  logic                 disp_valid_i,
  input  logic                 disp_is_br_i,
  output logic                 disp_ready_o,
  output logic [IDXW-1:0]      disp_tag_o,
  input  logic [NFIN-1:0]      fin_valid_i,
  input  logic [NFIN*IDXW-1:0] fin_tag_i,
  input  logic [NFIN-1:0]      fin_exc_i,
  input  logic                 br_valid_i,
  input  logic [IDXW-1:0]      br_tag_i,
  input  logic                 br_mispred_i,
  output logic [RETW-1:0]      ret_valid_o,
  output logic [RETW*IDXW-1:0] ret_tag_o,
  output logic                 exc_o
);

  cq_entry_t [DEPTH-1:0] ent_q;
  logic [IDXW-1:0] head_q, tail_q;
  logic [CNTW-1:0] count_q;
  logic [NW-1:0]   nret_w;

  // named internal events
  logic full_w, flush_w, push_w;
  logic [DEPTH-1:0] fin_hit, fin_bad, res_hit, kill_hit, ret_hit;

  assign full_w       = (count_q == CNTW'(DEPTH));
  assign flush_w      = br_valid_i & br_mispred_i & ent_q[br_tag_i].busy & ent_q[br_tag_i].is_br;
  assign disp_ready_o = ~full_w & ~flush_w;
  assign push_w       = disp_valid_i & disp_ready_o;
  assign disp_tag_o   = tail_q;

  cq_retire_sel #(.DEPTH(DEPTH), .RETW(RETW)) u_sel (
    .ent_i        (ent_q),
    .head_i       (head_q),
    .lane_go_o    (ret_valid_o),
    .lane_slot_o  (ret_tag_o),
    .nret_o       (nret_w),
    .head_fault_o (exc_o)
  );

  cq_ptr_ctl #(.DEPTH(DEPTH), .RETW(RETW)) u_ptr (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (clear_i),
    .push_i       (push_w),
    .nret_i       (nret_w),
    .flush_i      (flush_w),
    .flush_slot_i (br_tag_i),
    .head_o       (head_q),
    .tail_o       (tail_q),
    .count_o      (count_q)
  );

  // per-slot decode of finish, resolve, kill and retire events
  always_comb begin
    for (int s = 0; s < DEPTH; s++) begin
      logic hit, bad, rh;
      hit = 1'b0;
      bad = 1'b0;
      for (int p = 0; p < NFIN; p++) begin
        if (fin_valid_i[p] && fin_tag_i[p*IDXW +: IDXW] == IDXW'(s)) begin
          hit = 1'b1;
          bad = bad | fin_exc_i[p];
        end
      end
      fin_hit[s] = hit & ent_q[s].busy & ~ent_q[s].is_br;
      fin_bad[s] = bad;
      res_hit[s] = br_valid_i & (br_tag_i == IDXW'(s)) & ent_q[s].busy & ent_q[s].is_br;
      kill_hit[s] = flush_w & ent_q[s].busy &
                    (ring_dist(32'(head_q), 32'(s), DEPTH) >
                     ring_dist(32'(head_q), 32'(br_tag_i), DEPTH));
      rh = 1'b0;
      for (int l = 0; l < RETW; l++) begin
        if (ret_valid_o[l] && ret_tag_o[l*IDXW +: IDXW] == IDXW'(s)) rh = 1'b1;
      end
      ret_hit[s] = rh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= '0;
    end else if (clear_i) begin
      ent_q <= '0;
    end else begin
      for (int s = 0; s < DEPTH; s++) begin
        if (fin_hit[s]) begin
          ent_q[s].done  <= 1'b1;
          ent_q[s].fault <= fin_bad[s];
        end
        if (res_hit[s]) ent_q[s].done <= 1'b1;
        if (ret_hit[s] || kill_hit[s]) ent_q[s].busy <= 1'b0;
        if (push_w && tail_q == IDXW'(s)) begin
          ent_q[s].busy  <= 1'b1;
          ent_q[s].done  <= 1'b0;
          ent_q[s].fault <= 1'b0;
          ent_q[s].is_br <= disp_is_br_i;
        end
      end
    end
  end

endmodule

// File: rtl/cq_sva.sv
module cq_sva #(
  parameter int DEPTH = 16,
  parameter int IDXW  = 4,
  parameter int RETW  = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clear_i,
  input logic            disp_valid_i,
  input logic            disp_ready_o,
  input logic [IDXW-1:0] disp_tag_o,
  input logic [IDXW-1:0] br_tag_i,
  input logic [RETW-1:0] ret_valid_o,
  input logic            exc_o,
  input logic            flush_w
);

  logic [IDXW-1:0] tag_succ, br_succ;
  assign tag_succ = (disp_tag_o == IDXW'(DEPTH - 1)) ? '0 : disp_tag_o + 1'b1;
  assign br_succ  = (br_tag_i == IDXW'(DEPTH - 1)) ? '0 : br_tag_i + 1'b1;

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (ret_valid_o == '0 && !exc_o && disp_tag_o == '0)); // R1

  AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid_i && disp_ready_o && !clear_i) |=> disp_tag_o == $past(tag_succ)); // R2

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_ready_o && !flush_w && !clear_i) |=> $stable(disp_tag_o)); // R3

  AST_RET_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    ((ret_valid_o & (ret_valid_o + 1'b1)) == '0)); // R5

  AST_FLUSH_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_w && !clear_i) |=> disp_tag_o == $past(br_succ)); // R7

  AST_EXC_NO_RET: assert property (@(posedge clk) disable iff (!rst_n)
    exc_o |-> ret_valid_o == '0); // R8

  AST_FLUSH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    flush_w |-> !disp_ready_o); // R9

endmodule

bind inorder_cq cq_sva #(.DEPTH(DEPTH), .IDXW(IDXW), .RETW(RETW)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .clear_i      (clear_i),
  .disp_valid_i (disp_valid_i),
  .disp_ready_o (disp_ready_o),
  .disp_tag_o   (disp_tag_o),
  .br_tag_i     (br_tag_i),
  .ret_valid_o  (ret_valid_o),
  .exc_o        (exc_o),
  .flush_w      (flush_w)
);

// File: tb/inorder_cq_bench.sv
module inorder_cq_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int IDXW = 4;
  localparam int RETW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear_i = 1'b0;
  logic        disp_valid_i = 1'b0;
  logic        disp_is_br_i = 1'b0;
  logic        disp_ready_o;
  logic [3:0]  disp_tag_o;
  logic [1:0]  fin_valid_i = '0;
  logic [7:0]  fin_tag_i = '0;
  logic [1:0]  fin_exc_i = '0;
  logic        br_valid_i = 1'b0;
  logic [3:0]  br_tag_i = '0;
  logic        br_mispred_i = 1'b0;
  logic [3:0]  ret_valid_o;
  logic [15:0] ret_tag_o;
  logic        exc_o;

  int checks = 0;
  int errors = 0;
  int exp_q[$];

  always #10 clk = ~clk;

  inorder_cq u_inorder_cq (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  // monitor: compare every retiring lane with the scoreboard, R4 and R5
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      for (int l = 0; l < RETW; l++) begin
        if (ret_valid_o[l]) begin
          int got;
          got = int'(ret_tag_o[l*IDXW +: IDXW]);
          if (exp_q.size() == 0) chk(1'b0, "R4 unexpected retire", got, -1);
          else begin
            int e;
            e = exp_q.pop_front();
            chk(got == e, "R4/R5 retire order", got, e);
          end
        end
      end
    end
  end

  task automatic expect_ret(input int tag);
    exp_q.push_back(tag);
  endtask

  task automatic disp(input bit isbr, input int exp_tag, input string req);
    chk(disp_ready_o == 1'b1, req, int'(disp_ready_o), 1);
    chk(int'(disp_tag_o) == exp_tag, req, int'(disp_tag_o), exp_tag);
    disp_valid_i = 1'b1;
    disp_is_br_i = isbr;
    cyc();
    disp_valid_i = 1'b0;
    disp_is_br_i = 1'b0;
  endtask

  task automatic fin(input int port, input int tag, input bit exc);
    fin_valid_i[port] = 1'b1;
    fin_tag_i[port*IDXW +: IDXW] = 4'(tag);
    fin_exc_i[port] = exc;
    cyc();
    fin_valid_i = '0;
    fin_exc_i = '0;
  endtask

  task automatic resolve(input int tag, input bit mp);
    br_valid_i = 1'b1;
    br_tag_i = 4'(tag);
    br_mispred_i = mp;
    cyc();
    br_valid_i = 1'b0;
    br_mispred_i = 1'b0;
  endtask

  task automatic run_tests();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc();
    // R1 reset state
    chk(ret_valid_o == 4'h0, "R1 reset ret_valid", int'(ret_valid_o), 0);
    chk(exc_o == 1'b0, "R1 reset exc", int'(exc_o), 0);
    chk(disp_ready_o == 1'b1, "R1 reset ready", int'(disp_ready_o), 1);
    chk(disp_tag_o == 4'd0, "R1 reset tag", int'(disp_tag_o), 0);

    // R2, R4, R5: out-of-order finishes, then burst drain
    for (int i = 0; i < 6; i++) disp(1'b0, i, "R2 dispatch slot");
    for (int i = 5; i >= 1; i--) begin
      fin(0, i, 1'b0);
      chk(ret_valid_o == 4'h0, "R4 held behind oldest", int'(ret_valid_o), 0);
    end
    for (int i = 0; i < 6; i++) expect_ret(i);
    fin(0, 0, 1'b0);
    chk(ret_valid_o == 4'hF, "R5 four lanes", int'(ret_valid_o), 15);
    cyc();
    chk(ret_valid_o == 4'h3, "R5 partial group", int'(ret_valid_o), 3);
    cyc();
    chk(ret_valid_o == 4'h0, "R5 drained", int'(ret_valid_o), 0);

    // R6, R7, R9: branch gating and misprediction flush
    disp(1'b0, 6, "R2 slot 6");
    disp(1'b1, 7, "R2 slot 7");
    disp(1'b0, 8, "R2 slot 8");
    disp(1'b0, 9, "R2 slot 9");
    expect_ret(6);
    fin(0, 6, 1'b0);
    fin(0, 7, 1'b0);   // finish report on a branch: ignored (R6)
    fin(1, 8, 1'b0);
    fin(0, 9, 1'b0);
    chk(ret_valid_o == 4'h0, "R6 unresolved branch blocks", int'(ret_valid_o), 0);
    cyc();
    chk(ret_valid_o == 4'h0, "R6 still blocked", int'(ret_valid_o), 0);
    expect_ret(7);
    br_valid_i = 1'b1;
    br_tag_i = 4'd7;
    br_mispred_i = 1'b1;
    disp_valid_i = 1'b1;
    #1;
    chk(disp_ready_o == 1'b0, "R9 ready low on flush", int'(disp_ready_o), 0);
    cyc();
    br_valid_i = 1'b0;
    br_mispred_i = 1'b0;
    disp_valid_i = 1'b0;
    chk(disp_tag_o == 4'd8, "R7 tail after flush", int'(disp_tag_o), 8);
    chk(ret_valid_o == 4'h1, "R7 branch retires alone", int'(ret_valid_o), 1);
    cyc();
    chk(ret_valid_o == 4'h0, "R7 flushed entries gone", int'(ret_valid_o), 0);
    disp(1'b0, 8, "R9 dropped dispatch reused slot");
    cyc();
    chk(ret_valid_o == 4'h0, "R7 new entry unfinished", int'(ret_valid_o), 0);
    expect_ret(8);
    fin(0, 8, 1'b0);
    disp(1'b1, 9, "R2 slot 9 branch");
    expect_ret(9);
    resolve(9, 1'b0);
    chk(ret_valid_o == 4'h1, "R6 resolved branch retires", int'(ret_valid_o), 1);
    cyc();

    // R3: fill across the wrap, then drain with both finish ports
    for (int k = 0; k < 16; k++) disp(1'b0, (10 + k) % 16, "R3 fill slot");
    chk(disp_ready_o == 1'b0, "R3 full stalls", int'(disp_ready_o), 0);
    disp_valid_i = 1'b1;
    cyc();
    disp_valid_i = 1'b0;
    chk(disp_tag_o == 4'd10, "R3 tag held when full", int'(disp_tag_o), 10);
    chk(disp_ready_o == 1'b0, "R3 still full", int'(disp_ready_o), 0);
    for (int k = 0; k < 16; k++) expect_ret((10 + k) % 16);
    for (int k = 0; k < 16; k += 2) begin
      fin_valid_i = 2'b11;
      fin_tag_i = {4'((10 + k + 1) % 16), 4'((10 + k) % 16)};
      cyc();
      fin_valid_i = '0;
    end
    repeat (4) cyc();
    chk(disp_ready_o == 1'b1, "R3 ready after drain", int'(disp_ready_o), 1);

    // R8: fault raised only at the head, never retired; R1 clear
    disp(1'b0, 10, "R2 slot 10");
    disp(1'b0, 11, "R2 slot 11");
    fin(1, 11, 1'b1);
    chk(exc_o == 1'b0, "R8 younger fault silent", int'(exc_o), 0);
    expect_ret(10);
    fin(0, 10, 1'b0);
    cyc();
    chk(exc_o == 1'b1, "R8 fault at head", int'(exc_o), 1);
    chk(ret_valid_o == 4'h0, "R8 fault not retired", int'(ret_valid_o), 0);
    cyc();
    chk(exc_o == 1'b1, "R8 fault held", int'(exc_o), 1);
    clear_i = 1'b1;
    disp_valid_i = 1'b1;
    cyc();
    clear_i = 1'b0;
    disp_valid_i = 1'b0;
    chk(exc_o == 1'b0, "R1 clear exc", int'(exc_o), 0);
    chk(disp_tag_o == 4'd0, "R1 clear tag", int'(disp_tag_o), 0);
    chk(disp_ready_o == 1'b1, "R1 clear ready", int'(disp_ready_o), 1);
    chk(ret_valid_o == 4'h0, "R1 clear ret", int'(ret_valid_o), 0);
    repeat (3) cyc();
    chk(exp_q.size() == 0, "R4 all expected retired", exp_q.size(), 0);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule